// File: doc/BRIEF.md
# Real-Time Clock Interrupt Flag and Request Unit

This block is the status and interrupt section of a real-time clock. It watches three event sources: a periodic event taken from a selectable tap of an internal binary divider, an alarm event raised when the current time agrees with stored alarm fields, and an update-ended event raised each time the time counter finishes an update. Each source sets its own sticky flag. The host reads all flags through one status register, and that read clears them. Per-source enable bits decide which flags take part in a summary request bit, and that bit drives an active-low interrupt line.

The time counter is not part of the block. Its current time fields arrive on an input vector, and its end-of-update strobe arrives on a single-cycle input. The divider advances on a single-cycle input strobe that marks each period of the 32768 Hz time base. The host uses a simple register port: address, write strobe, read strobe, write data and combinational read data. A read with `reg_rd` high at the status address clears the flags at the following clock edge.

Top module: `rtc_irq_unit`

## Requirements
- R1: The status register (address 4) reads {summary, periodic flag, alarm flag, update flag, 4'b0000}, with bit 7 first. Its bits 3..0 always read 0. Writes to it change no flag.
- R2: The summary bit is (periodic flag & periodic enable) | (alarm flag & alarm enable) | (update flag & update enable). `irq_n` is 0 exactly when the summary bit is 1.
- R3: A status read clears every flag at the next clock edge. A clock edge with `rst_n` low also clears every flag and every register.
- R4: A flag whose event happens in the same cycle as a status read is still set after that read.
- R5: Control register (address 3) bits 3..0 select the periodic rate. Code 0 yields no periodic events. Codes 1 and 2 give one event every 128 and 256 base ticks. Code c from 3 to 15 gives one event every 2^(c-1) base ticks, so code 3 gives 8192 Hz and code 15 gives 2 Hz.
- R6: The periodic flag sets whatever the value of its enable bit.
- R7: The alarm flag sets on an update strobe when every alarm field equals its time field. An alarm field whose two top bits are both 1 (0xC0 to 0xFF) matches any time value.
- R8: The update flag sets on every update strobe.
- R9: The validity register (address 5) always reads 0x80 and ignores writes.
- R10: Alarm fields (addresses 0 to 2, seconds first) read back as written. Control bits 4, 5 and 6 are the update, alarm and periodic enables, and bit 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| base_tick | input | 1 | One-cycle strobe per 32768 Hz base period |
| upd_done | input | 1 | One-cycle strobe at the end of each time update |
| cur_time | input | 24 | Current time fields, seconds in bits 7:0, then minutes, then hours |
| reg_addr | input | 3 | Host register address |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe (clears flags at the status address) |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data, combinational |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
A status read can fall in the same clock cycle as a flag-setting event, and a careless clear would then lose the event. The bench pulses the update strobe in the cycle of a status read. It expects that read to return the flag still clear and the next read to return it set. The periodic intervals are also measured while the status register is read every cycle. An event that arrives together with a clear would show up there as a missing period.

// File: rtl/rtc_irq_pkg.sv
// Package: shared types and helpers of the RTC interrupt unit.
// Assumes an 8-bit host data path and a 4-bit rate-select code.
package rtc_irq_pkg;

    localparam int RATE_W = 4;

    // Sticky event flags in the order they appear in the status byte.
    typedef struct packed {
        logic per;
        logic alm;
        logic upd;
    } evt_flags_t;

    // Divider bit whose rising edge is the periodic event for a rate code; -1 = off.
    function automatic int rate_tap_bit(input logic [RATE_W-1:0] code);
        case (code)
            4'd0:    return -1;
            4'd1:    return 6;
            4'd2:    return 7;
            default: return int'(code) - 2;
        endcase
    endfunction

endpackage

// File: rtl/rtc_div_tap.sv
// Module: binary divider of the base tick with a selectable rising-edge tap.
// Assumes base_tick is a single-cycle strobe. An event is reported in the
// cycle whose tick makes the selected divider bit go from 0 to 1.
module rtc_div_tap
    import rtc_irq_pkg::*;
#(
    parameter int DIV_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_tick,
    input  logic [RATE_W-1:0] rate_sel,
    output logic              per_evt
);

    logic [DIV_W-1:0] div_q;

    // Divider count: advances once per base tick.
    always_ff @(posedge clk) begin
        if (!rst_n)         div_q <= '0;
        else if (base_tick) div_q <= div_q + 1'b1;
    end

    // Tap decode: the next count has the tap bit set and all lower bits clear.
    always_comb begin
        int               tap;
        logic [DIV_W-1:0] nxt;
        logic [DIV_W-1:0] low_mask;
        logic [DIV_W-1:0] tap_mask;
        tap      = rate_tap_bit(rate_sel);
        nxt      = div_q + 1'b1;
        low_mask = '0;
        tap_mask = '0;
        for (int b = 0; b < DIV_W; b++) begin
            if (b < tap)  low_mask[b] = 1'b1;
            if (b == tap) tap_mask[b] = 1'b1;
        end
        per_evt = base_tick && (tap_mask != '0) &&
                  ((nxt & (low_mask | tap_mask)) == tap_mask);
    end

    // R5: the shortest period is several ticks, so events never come back to back.
    p_no_back_to_back_r5: assert property (@(posedge clk) disable iff (!rst_n)
        per_evt |=> !per_evt);

    // R5: with the source switched off, no event is produced.
    p_off_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_sel == '0) |-> !per_evt);

endmodule

// File: rtl/rtc_alarm_cmp.sv
// Module: alarm comparator with per-field wildcard.
// Assumes the time fields are stable while upd_done is high. A field whose
// two top bits are set matches any time value.
module rtc_alarm_cmp #(
    parameter int N_FLD = 3,
    parameter int FLD_W = 8
) (
    input  logic [N_FLD*FLD_W-1:0] alarm_vec,
    input  logic [N_FLD*FLD_W-1:0] time_vec,
    input  logic                   upd_done,
    output logic                   alm_evt
);

    logic [N_FLD-1:0] fld_hit;

    // One comparator per field: exact match or wildcard.
    for (genvar i = 0; i < N_FLD; i++) begin : g_fld
        logic [FLD_W-1:0] a_f;
        logic [FLD_W-1:0] t_f;
        assign a_f        = alarm_vec[i*FLD_W +: FLD_W];
        assign t_f        = time_vec[i*FLD_W +: FLD_W];
        assign fld_hit[i] = (a_f[FLD_W-1 -: 2] == 2'b11) || (a_f == t_f);
    end

    // Event only at the end of an update, when every field hits.
    assign alm_evt = upd_done && (&fld_hit);

    // R7: an alarm event never occurs outside an update strobe.
    always_comb begin
        p_alarm_on_update_r7: assert (!alm_evt || upd_done);
    end

endmodule

// File: rtl/rtc_flag_bank.sv
// Module: sticky event flags with clear-on-read and the summary request.
// Assumes clr_rd is high for one cycle per status read. An event in the
// cycle of the clear wins, so it is not lost.
module rtc_flag_bank
    import rtc_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       per_evt,
    input  logic       alm_evt,
    input  logic       upd_evt,
    input  logic       clr_rd,
    input  logic       en_per,
    input  logic       en_alm,
    input  logic       en_upd,
    output evt_flags_t flags,
    output logic       summary
);

    evt_flags_t evt;

    assign evt = '{per: per_evt, alm: alm_evt, upd: upd_evt};

    // Flag state: cleared by reset or read, then new events OR-ed in.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (clr_rd ? evt_flags_t'('0) : flags) | evt;
    end

    // Summary request from the enabled flags.
    assign summary = (flags.per & en_per) | (flags.alm & en_alm) | (flags.upd & en_upd);

    // R4: an update event during a read survives the clear.
    p_keep_on_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_rd && upd_evt) |=> flags.upd);

    // R3: a read with no event leaves every flag clear.
    p_clear_on_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_rd && !per_evt && !alm_evt && !upd_evt) |=> (flags == '0));

    // R6: the periodic flag holds until a read, whatever its enable.
    p_per_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flags.per && !clr_rd) |=> flags.per);

endmodule

// File: rtl/rtc_irq_unit.sv
// Module: top of the RTC status and interrupt unit.
// Holds the alarm fields and the control byte, decodes host accesses and
// ties the divider tap, the alarm comparator and the flag bank together.
// Assumes read data is taken in the cycle of reg_rd and that the time
// counter outside supplies cur_time and upd_done.
module rtc_irq_unit
    import rtc_irq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int N_ALM  = 3,
    parameter int DIV_W  = 15,
    parameter int ADDR_W = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    base_tick,
    input  logic                    upd_done,
    input  logic [N_ALM*DATA_W-1:0] cur_time,
    input  logic [ADDR_W-1:0]       reg_addr,
    input  logic                    reg_wr,
    input  logic                    reg_rd,
    input  logic [DATA_W-1:0]       reg_wdata,
    output logic [DATA_W-1:0]       reg_rdata,
    output logic                    irq_n
);

    localparam logic [ADDR_W-1:0] CTRL_A  = ADDR_W'(N_ALM);
    localparam logic [ADDR_W-1:0] STAT_A  = ADDR_W'(N_ALM + 1);
    localparam logic [ADDR_W-1:0] VALID_A = ADDR_W'(N_ALM + 2);
    localparam int                LOW_W   = DATA_W - 4;

    logic [DATA_W-1:0]       alm_q [N_ALM];
    logic [N_ALM*DATA_W-1:0] alm_flat;
    logic [RATE_W-1:0]       rate_q;
    logic                    en_per_q, en_alm_q, en_upd_q;
    logic                    per_evt, alm_evt, summary, stat_rd;
    evt_flags_t              flags;

    for (genvar i = 0; i < N_ALM; i++) begin : g_flat
        assign alm_flat[i*DATA_W +: DATA_W] = alm_q[i];
    end

    // Host writes to the alarm fields and the control byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_ALM; i++) alm_q[i] <= '0;
            rate_q   <= '0;
            en_per_q <= 1'b0;
            en_alm_q <= 1'b0;
            en_upd_q <= 1'b0;
        end else if (reg_wr) begin
            for (int i = 0; i < N_ALM; i++)
                if (reg_addr == ADDR_W'(i)) alm_q[i] <= reg_wdata;
            if (reg_addr == CTRL_A) begin
                rate_q   <= reg_wdata[RATE_W-1:0];
                en_upd_q <= reg_wdata[4];
                en_alm_q <= reg_wdata[5];
                en_per_q <= reg_wdata[6];
            end
        end
    end

    assign stat_rd = reg_rd && (reg_addr == STAT_A);

    // Host read mux; status and validity are formed from live state.
    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < N_ALM; i++)
            if (reg_addr == ADDR_W'(i)) reg_rdata = alm_q[i];
        if (reg_addr == CTRL_A)
            reg_rdata = {1'b0, en_per_q, en_alm_q, en_upd_q, rate_q};
        if (reg_addr == STAT_A)
            reg_rdata = {summary, flags.per, flags.alm, flags.upd, {LOW_W{1'b0}}};
        if (reg_addr == VALID_A)
            reg_rdata = {1'b1, {(DATA_W-1){1'b0}}};
    end

    rtc_div_tap #(.DIV_W(DIV_W)) div_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .base_tick(base_tick),
        .rate_sel (rate_q),
        .per_evt  (per_evt)
    );

    rtc_alarm_cmp #(.N_FLD(N_ALM), .FLD_W(DATA_W)) alm_i (
        .alarm_vec(alm_flat),
        .time_vec (cur_time),
        .upd_done (upd_done),
        .alm_evt  (alm_evt)
    );

    rtc_flag_bank flag_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .per_evt(per_evt),
        .alm_evt(alm_evt),
        .upd_evt(upd_done),
        .clr_rd (stat_rd),
        .en_per (en_per_q),
        .en_alm (en_alm_q),
        .en_upd (en_upd_q),
        .flags  (flags),
        .summary(summary)
    );

    assign irq_n = ~summary;

    // R2: the request line agrees with the summary bit seen by the host.
    p_irq_matches_status_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |-> (irq_n == !reg_rdata[DATA_W-1]));

    // R1: the reserved low bits of the status byte read as zero.
    p_status_low_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == STAT_A) |-> (reg_rdata[LOW_W-1:0] == '0));

    // R8: every update strobe leaves the update flag set.
    p_update_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
        upd_done |=> flags.upd);

    // R9: the validity byte never changes.
    p_valid_const_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == VALID_A) |-> (reg_rdata == {1'b1, {(DATA_W-1){1'b0}}}));

endmodule

// File: tb/rtc_irq_unit_tb.sv
// Bench: sweeps rate codes, alarm field patterns and enable combinations,
// with expected values worked out from the requirements.
module rtc_irq_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        base_tick = 1'b0;
    logic        upd_done = 1'b0;
    logic [23:0] cur_time = '0;
    logic [2:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        irq_n;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] q;

    localparam logic [2:0] CTRL = 3'd3, STAT = 3'd4, VALID = 3'd5;

    always #5 clk = ~clk;

    rtc_irq_unit dut_i (
        .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .upd_done(upd_done),
        .cur_time(cur_time), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_n(irq_n)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // One bus cycle: drive at the falling edge, sample read data, release after the rising edge.
    task automatic access(input logic [2:0] a, input bit wr, input bit rd,
                          input logic [7:0] d, input bit upd);
        @(negedge clk);
        reg_addr = a; reg_wr = wr; reg_rd = rd; reg_wdata = d; upd_done = upd;
        #1 q = reg_rdata;
        @(posedge clk);
        #1 reg_wr = 1'b0; reg_rd = 1'b0; upd_done = 1'b0;
    endtask

    function automatic int period_of(input int c);
        if (c == 1) return 128;
        if (c == 2) return 256;
        return 1 << (c - 1);
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=0x1 expected=0x0");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // Reset state (R3, R9)
        access(STAT, 0, 1, 8'h00, 0);
        check(q == 8'h00, "R3 reset status", q, 0);
        check(irq_n == 1'b1, "R2 reset irq_n", irq_n, 1);
        access(VALID, 0, 1, 8'h00, 0);
        check(q == 8'h80, "R9 reset valid", q, 8'h80);

        // Register readback (R10) and ignored writes (R9, R1)
        for (int i = 0; i < 3; i++) access(3'(i), 1, 0, 8'(8'h11 * (i + 3)), 0);
        for (int i = 0; i < 3; i++) begin
            access(3'(i), 0, 1, 8'h00, 0);
            check(q == 8'(8'h11 * (i + 3)), "R10 alarm readback", q, 8'h11 * (i + 3));
        end
        access(CTRL, 1, 0, 8'hF0, 0);
        access(CTRL, 0, 1, 8'h00, 0);
        check(q == 8'h70, "R10 control readback", q, 8'h70);
        access(CTRL, 1, 0, 8'h00, 0);
        access(VALID, 1, 0, 8'h00, 0);
        access(VALID, 0, 1, 8'h00, 0);
        check(q == 8'h80, "R9 write ignored", q, 8'h80);
        access(STAT, 1, 0, 8'hFF, 0);
        access(STAT, 0, 1, 8'h00, 0);
        check(q == 8'h00, "R1 status write ignored", q, 0);

        // Update flag and same-cycle read (R8, R4, R3)
        access(STAT, 0, 1, 8'h00, 1);
        check(q == 8'h00, "R4 read during event shows old", q, 0);
        access(STAT, 0, 1, 8'h00, 0);
        check(q[4] == 1'b1, "R4 event kept across read", q, 8'h10);
        check(q[3:0] == 4'h0, "R1 reserved bits zero", q[3:0], 0);
        access(STAT, 0, 1, 8'h00, 0);
        check(q == 8'h00, "R3 cleared after read", q, 0);
        access(STAT, 0, 0, 8'h00, 1);
        access(STAT, 0, 1, 8'h00, 0);
        check(q == 8'h10, "R8 update flag set", q, 8'h10);

        // Alarm sweep with wildcard (R7)
        cur_time = 24'h0D_2A_17;
        foreach (cur_time[i]) ;
        for (int f = 0; f < 3; f++) begin
            for (int k = 0; k < 7; k++) begin
                logic [7:0] vals [7];
                logic [23:0] av;
                bit exp_af;
                vals = '{8'h00, 8'h3B, 8'hBF, 8'hC0, 8'hD5, 8'hFF, 8'h17};
                av = 24'h0D_2A_17;
                cur_time = 24'h0D_2A_17;
                cur_time[f*8 +: 8] = 8'h17;
                av[f*8 +: 8] = vals[k];
                exp_af = (vals[k] >= 8'hC0) || (vals[k] == 8'h17);
                for (int i = 0; i < 3; i++) access(3'(i), 1, 0, av[i*8 +: 8], 0);
                access(STAT, 0, 1, 8'h00, 0);
                access(STAT, 0, 0, 8'h00, 1);
                access(STAT, 0, 1, 8'h00, 0);
                check(q[5] == exp_af, "R7 alarm match", q[5], exp_af);
                check(q[4] == 1'b1, "R8 update with alarm", q[4], 1);
            end
        end

        // Enable sweep (R2) with two flag patterns
        for (int en = 0; en < 8; en++) begin
            for (int pat = 0; pat < 2; pat++) begin
                bit exp_sum;
                for (int i = 0; i < 3; i++) access(3'(i), 1, 0, pat ? 8'h00 : 8'hFF, 0);
                access(CTRL, 1, 0, 8'(en << 4) | (pat ? 8'h00 : 8'h03), 0);
                access(STAT, 0, 1, 8'h00, 0);
                if (!pat) begin
                    base_tick = 1'b1;
                    repeat (8) @(posedge clk);
                    #1 base_tick = 1'b0;
                end
                access(STAT, 0, 0, 8'h00, 1);
                exp_sum = pat ? en[0] : (en != 0);
                @(negedge clk);
                check(irq_n == !exp_sum, "R2 irq_n from enables", irq_n, !exp_sum);
                access(STAT, 0, 1, 8'h00, 0);
                check(q[7] == exp_sum, "R2 summary bit", q[7], exp_sum);
                check(q[6:4] == (pat ? 3'b001 : 3'b111), "R1 flag layout", q[6:4],
                      pat ? 1 : 7);
            end
        end

        // Periodic rate sweep, enable off (R5, R6)
        access(CTRL, 1, 0, 8'h00, 0);
        access(STAT, 0, 1, 8'h00, 0);
        base_tick = 1'b1;
        begin
            int seen;
            seen = 0;
            for (int t = 0; t < 600; t++) begin
                access(STAT, 0, 1, 8'h00, 0);
                if (q[6]) seen++;
            end
            check(seen == 0, "R5 code 0 silent", seen, 0);
        end
        for (int c = 1; c < 16; c++) begin
            int p, t, last, got;
            bit found, irq_ok;
            p = period_of(c);
            access(CTRL, 1, 0, 8'(c), 0);
            access(STAT, 0, 1, 8'h00, 0);
            access(STAT, 0, 1, 8'h00, 0);
            last = -1; got = 0; t = 0; irq_ok = 1'b1;
            while (got < 2 && t < 3 * p + 8) begin
                access(STAT, 0, 1, 8'h00, 0);
                if (q[6]) begin
                    if (irq_n !== 1'b1 || q[7]) irq_ok = 1'b0;
                    if (last >= 0) begin
                        check(t - last == p, "R5 periodic interval", t - last, p);
                        got++;
                    end
                    last = t;
                end
                t++;
            end
            found = (got == 2);
            check(found, "R5 periodic events seen", got, 2);
            check(irq_ok, "R6 flag set with enable off", irq_ok, 1);
        end
        base_tick = 1'b0;

        // Reset clears flags and registers (R3)
        access(STAT, 0, 0, 8'h00, 1);
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        access(STAT, 0, 1, 8'h00, 0);
        check(q == 8'h00, "R3 reset clears flags", q, 0);
        access(CTRL, 0, 1, 8'h00, 0);
        check(q == 8'h00, "R3 reset clears control", q, 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule